// File: doc/BRIEF.md
# Byte Stream Port Device

This block is a peripheral on a processor I/O port bus with 256 ports and 32-bit data. Bytes arrive from an external source on a valid/ready stream and wait in a small first-in first-out store. The processor reads a count port to learn how many bytes are waiting. It reads a data port to take the oldest one, and each such read removes exactly that byte. While anything is waiting, the block holds an interrupt request high on a fixed vector, so a handler can drain the store.

For output, the processor writes a word to a third port. The low byte goes out on a second valid/ready stream. A one-byte holding register absorbs a single write while the output stream is stalled. Any further write made before the held byte leaves is thrown away and raises a sticky flag.

Back-pressure rules: a byte moves on either stream only in a cycle where valid and ready are both high. `rx_ready` drops while the store is full. Once `tx_valid` is raised, it and `tx_data` stay unchanged until the sink takes the byte. Port reads are combinational on the current address. The effect of a data-port read (removal of the byte) occurs at the clock edge that ends the strobe cycle.

Top module: `bytes_port_dev`

## Requirements
- R1: A read of port 8 returns the number of waiting bytes in bits 15:0 and zero in bits 31:16. The read has no side effect.
- R2: A read of port 9 returns the oldest waiting byte in bits 7:0 and zero in bits 31:8. Bytes come out in arrival order.
- R3: Each port-9 read made while the count is nonzero lowers the count by exactly one.
- R4: A port-9 read while the count is zero returns 0 and leaves the count at 0.
- R5: If a byte is accepted on the input stream in the same cycle as a port-9 read with a nonzero count, the count is unchanged and both bytes keep their order.
- R6: The store holds 16 bytes. `rx_ready` is low while 16 are waiting, and a byte offered then is not stored.
- R7: `irq_req` is high exactly while the count is nonzero. `irq_vector` is always 8.
- R8: A write to port 12 sets `tx_valid` and puts bits 7:0 of the word on `tx_data` from the next cycle. Bits 31:8 are ignored.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` stay unchanged.
- R10: A port-12 write while a held byte is not being taken is dropped and sets `tx_overflow`. The flag clears when the held byte is accepted. A write in the same cycle that the held byte is accepted replaces it.
- R11: After reset the count is 0, `irq_req`, `tx_valid` and `tx_overflow` are low, and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_addr | input | 8 | I/O port number |
| port_rd | input | 1 | Read strobe |
| port_wr | input | 1 | Write strobe |
| port_wdata | input | 32 | Write data |
| port_rdata | output | 32 | Read data for the addressed port |
| irq_req | output | 1 | Level interrupt request, high while bytes wait |
| irq_vector | output | 6 | Interrupt vector number (8) |
| rx_valid | input | 1 | Input byte offered |
| rx_data | input | 8 | Input byte |
| rx_ready | output | 1 | Block can accept an input byte |
| tx_valid | output | 1 | Output byte held |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Sink takes the output byte |
| tx_overflow | output | 1 | Sticky flag: an output write was dropped |

## Verification
The bench builds the block with its default parameters. These are a 16-byte store, ports 8, 9 and 12, and vector 8. With a store this shallow, the full boundary and the refusal of a seventeenth byte are reached in a few dozen cycles. A complete drain afterwards shows the ordering across a full wrap of the pointers. The shallow store also makes the empty-read corner, the simultaneous push and pop, and the stalled-output drop reachable in short directed sequences.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_OUT  = 2'd3
  } port_sel_e;
endpackage

// File: rtl/bpd_port_decode.sv
module bpd_port_decode
  import bpd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_PORT  = 8,
  parameter int DATA_PORT = 9,
  parameter int OUT_PORT  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output port_sel_e         sel,
  output logic              pop_req,
  output logic              out_wr
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(CNT_PORT))       sel = SEL_CNT;
    else if (addr == ADDR_W'(DATA_PORT)) sel = SEL_DATA;
    else if (addr == ADDR_W'(OUT_PORT))  sel = SEL_OUT;
  end

  assign pop_req = rd && (sel == SEL_DATA);
  assign out_wr  = wr && (sel == SEL_OUT);
endmodule

// File: rtl/bpd_rx_fifo.sv
module bpd_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  output logic             in_ready,
  input  logic             pop_req,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] level,
  output logic             nonempty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push, pop;

  assign nonempty = (level != '0);
  assign in_ready = (level != CNT_W'(DEPTH));
  assign push     = in_valid && in_ready;
  assign pop      = pop_req && nonempty;
  assign head     = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/bpd_tx_hold.sv
module bpd_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_byte,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  input  logic         tx_ready,
  output logic         overflow
);
  logic take, accept;

  assign take   = tx_valid && tx_ready;
  assign accept = wr_en && (!tx_valid || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) begin
        tx_valid <= 1'b1;
        tx_data  <= wr_byte;
      end else if (take) begin
        tx_valid <= 1'b0;
      end
      if (wr_en && !accept) overflow <= 1'b1;
      else if (take)        overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/bytes_port_dev.sv
module bytes_port_dev
  import bpd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int CNT_PORT    = 8,
  parameter int DATA_PORT   = 9,
  parameter int OUT_PORT    = 12,
  parameter int VEC_W       = 6,
  parameter int IRQ_VEC     = 8,
  parameter int CNT_FIELD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              port_rd,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] port_wdata,
  output logic [DATA_W-1:0] port_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              tx_overflow
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  port_sel_e         sel;
  logic              pop_req, out_wr, rx_nonempty;
  logic [BYTE_W-1:0] rx_head;
  logic [CNT_W-1:0]  rx_level;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^port_wdata[DATA_W-1:BYTE_W];

  bpd_port_decode #(
    .ADDR_W(ADDR_W), .CNT_PORT(CNT_PORT), .DATA_PORT(DATA_PORT), .OUT_PORT(OUT_PORT)
  ) u_dec (
    .addr(port_addr), .rd(port_rd), .wr(port_wr),
    .sel(sel), .pop_req(pop_req), .out_wr(out_wr)
  );

  bpd_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .pop_req(pop_req), .head(rx_head), .level(rx_level), .nonempty(rx_nonempty)
  );

  bpd_tx_hold #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(out_wr), .wr_byte(port_wdata[BYTE_W-1:0]),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .overflow(tx_overflow)
  );

  always_comb begin
    port_rdata = '0;
    case (sel)
      SEL_CNT:  port_rdata[CNT_FIELD_W-1:0] = CNT_FIELD_W'(rx_level);
      SEL_DATA: if (rx_nonempty) port_rdata[BYTE_W-1:0] = rx_head;
      default:  port_rdata = '0;
    endcase
  end

  assign irq_req    = rx_nonempty;
  assign irq_vector = VEC_W'(IRQ_VEC);
endmodule

// File: rtl/bpd_chk.sv
module bpd_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int DEPTH     = 16,
  parameter int CNT_PORT  = 8,
  parameter int DATA_PORT = 9,
  parameter int CNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] port_addr,
  input logic              port_rd,
  input logic [DATA_W-1:0] port_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              irq_req,
  input logic [CNT_W-1:0]  level
);
  logic rd_data_w, push_w;
  assign rd_data_w = port_rd && (port_addr == ADDR_W'(DATA_PORT));
  assign push_w    = rx_valid && rx_ready;

  // R1
  cnt_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_addr == ADDR_W'(CNT_PORT)) |-> (port_rdata == DATA_W'(level)));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_w && level != '0 && !push_w) |=> (level == CNT_W'($past(level) - 1'b1)));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_w && level == '0) |-> (port_rdata == '0));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_w && level != '0 && push_w) |=> $stable(level));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= CNT_W'(DEPTH)) |-> (!rx_ready && level == CNT_W'(DEPTH)));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (level != '0));

  // R9
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind bytes_port_dev bpd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(FIFO_DEPTH),
  .CNT_PORT(CNT_PORT), .DATA_PORT(DATA_PORT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_rd(port_rd),
  .port_rdata(port_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .irq_req(irq_req), .level(rx_level)
);

// File: tb/bytes_port_dev_tb.sv
module bytes_port_dev_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] P_CNT = 8'd8, P_DAT = 8'd9, P_OUT = 8'd12;
  localparam logic [1:0] OP_PUSH = 2'd0, OP_RCNT = 2'd1, OP_RDAT = 2'd2, OP_WOUT = 2'd3;
  localparam int NV = 12;
  // {op, argument, expected}
  localparam logic [65:0] VECS [NV] = '{
    {OP_PUSH, 32'h0000_0011, 32'h1},
    {OP_PUSH, 32'h0000_00A5, 32'h1},
    {OP_PUSH, 32'h0000_007E, 32'h1},
    {OP_RCNT, 32'h0,         32'h3},
    {OP_RDAT, 32'h0,         32'h11},
    {OP_RCNT, 32'h0,         32'h2},
    {OP_RDAT, 32'h0,         32'hA5},
    {OP_RDAT, 32'h0,         32'h7E},
    {OP_RCNT, 32'h0,         32'h0},
    {OP_WOUT, 32'hDEAD_BE3C, 32'h3C},
    {OP_WOUT, 32'h0000_01FF, 32'hFF},
    {OP_RCNT, 32'h0,         32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  port_addr = '0;
  logic        port_rd = 1'b0, port_wr = 1'b0;
  logic [31:0] port_wdata = '0;
  logic [31:0] port_rdata;
  logic        irq_req;
  logic [5:0]  irq_vector;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, tx_overflow;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bytes_port_dev u_dut (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_rd(port_rd),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .irq_req(irq_req), .irq_vector(irq_vector), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .tx_overflow(tx_overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    #1;
  endtask

  task automatic rd_port(input logic [7:0] a, output logic [31:0] val);
    @(negedge clk); port_addr = a; port_rd = 1'b1;
    #1 val = port_rdata;
    @(negedge clk); port_rd = 1'b0;
    #1;
  endtask

  task automatic wr_port(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); port_addr = a; port_wr = 1'b1; port_wdata = d;
    @(negedge clk); port_wr = 1'b0;
    #1;
  endtask

  task automatic drain_tx;
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 irq", 32'(irq_req), 32'h0);
    chk("R11 tx_valid", 32'(tx_valid), 32'h0);
    chk("R11 overflow", 32'(tx_overflow), 32'h0);
    chk("R11 rx_ready", 32'(rx_ready), 32'h1);
    chk("R7 vector", 32'(irq_vector), 32'h8);
    rd_port(P_CNT, v); chk("R11 count", v, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i][65:64])
        OP_PUSH: begin push(VECS[i][39:32]); chk("R7 irq after push", 32'(irq_req), VECS[i][31:0]); end
        OP_RCNT: begin rd_port(P_CNT, v); chk("R1 count", v, VECS[i][31:0]); end
        OP_RDAT: begin rd_port(P_DAT, v); chk("R2 data", v, VECS[i][31:0]); end
        default: begin
          wr_port(P_OUT, VECS[i][63:32]);
          chk("R8 tx_valid", 32'(tx_valid), 32'h1);
          chk("R8 tx_data", 32'(tx_data), VECS[i][31:0]);
          drain_tx;
        end
      endcase
    end

    // R4 empty read
    rd_port(P_DAT, v); chk("R4 empty data", v, 32'h0);
    rd_port(P_CNT, v); chk("R4 count stays", v, 32'h0);
    chk("R7 irq idle", 32'(irq_req), 32'h0);

    // R3 decrement by one
    push(8'h21); push(8'h22);
    rd_port(P_DAT, v); chk("R3 first", v, 32'h21);
    rd_port(P_CNT, v); chk("R3 count", v, 32'h1);

    // R5 simultaneous push and pop
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h55; port_addr = P_DAT; port_rd = 1'b1;
    #1 v = port_rdata;
    chk("R5 read value", v, 32'h22);
    @(negedge clk); rx_valid = 1'b0; port_rd = 1'b0;
    rd_port(P_CNT, v); chk("R5 count unchanged", v, 32'h1);
    rd_port(P_DAT, v); chk("R5 order", v, 32'h55);

    // R6 full store and refusal
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(8'h40 + i);
    end
    @(negedge clk); rx_data = 8'hEE;
    #1 chk("R6 ready low", 32'(rx_ready), 32'h0);
    @(negedge clk); rx_valid = 1'b0;
    rd_port(P_CNT, v); chk("R6 count 16", v, 32'd16);
    chk("R7 irq full", 32'(irq_req), 32'h1);
    for (int i = 0; i < 16; i++) begin
      rd_port(P_DAT, v); chk("R6 drain order", v, 32'(8'h40 + i));
    end
    rd_port(P_CNT, v); chk("R6 nothing extra", v, 32'h0);
    chk("R7 irq drained", 32'(irq_req), 32'h0);

    // R9 and R10 stalled output
    wr_port(P_OUT, 32'h1122_3344);
    wr_port(P_OUT, 32'h0000_0099);
    chk("R10 overflow set", 32'(tx_overflow), 32'h1);
    repeat (3) @(negedge clk);
    #1 chk("R9 held data", 32'(tx_data), 32'h44);
    chk("R9 held valid", 32'(tx_valid), 32'h1);
    @(negedge clk);
    tx_ready = 1'b1; port_addr = P_OUT; port_wr = 1'b1; port_wdata = 32'h0000_0077;
    @(negedge clk); tx_ready = 1'b0; port_wr = 1'b0;
    #1;
    chk("R10 replace data", 32'(tx_data), 32'h77);
    chk("R10 replace valid", 32'(tx_valid), 32'h1);
    chk("R10 overflow cleared", 32'(tx_overflow), 32'h0);
    drain_tx;
    chk("R8 taken", 32'(tx_valid), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule